// File: doc/BRIEF.md
# Directional Binary Flood-Fill Grid

This block holds a rectangular grid of one-bit cells and spreads a binary "reached" mark outward from a set of seed cells. The mark moves only along the orthogonal directions that the caller enables for the operation. It enters a cell only if that cell's mask bit is set. When no more cells can be reached, the reached plane is the flood fill of the masked region from the seeds. Typical uses are picking out one closed shape from a binary image, or filling the inside or the outside of a contour.

The caller presents a seed plane, a mask plane and a four-bit direction field, and pulses `start` for one cycle. The fill then advances exactly one cell hop per clock. `done` rises on the first cycle in which a step adds no new cell. The result stays on `reachedPlane` until the next `start`.

Planes are flattened row-major: cell (row r, column c) is bit `r*COLS + c`, and row 0 is the north edge.

Top module: `flood_fill_array`

## Requirements
- R1: While `rstN` is low, and after it is released with no `start`, `reachedPlane` is all zeros and `done` is low.
- R2: On the edge where `start` is high, the reached plane is replaced by `seedPlane` exactly, whatever the mask, and `done` goes low.
- R3: On each fill step, an unreached cell becomes reached if its mask bit is set and a reached neighbour lies upstream in an enabled direction. `dirEn` bit 0 lets the mark move north (from the south neighbour). Bit 1 lets it move south (from the north neighbour). Bit 2 lets it move east (from the west neighbour). Bit 3 lets it move west (from the east neighbour). The mark advances one hop per clock.
- R4: The mark never moves in a direction whose `dirEn` bit is clear. It never enters a cell whose mask bit is clear, unless that cell is a seed.
- R5: Cells beyond the grid edge count as unreached. The mark does not wrap from the last column of one row to the first column of the next row, nor the reverse.
- R6: If the final fill needs k hops, `done` is low after k edges that follow the start edge, and high after k+1 such edges.
- R7: Between two `start` pulses, no reached bit is ever cleared. Once `done` is high, both `done` and the reached plane hold until the next `start`.
- R8: The mask and direction inputs are captured on the start edge. Changes to them during a fill have no effect on that fill.
- R9: A `start` that arrives during a fill abandons that fill and begins a new one from the new seeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that loads seeds and captures the mask and directions |
| seedPlane | input | ROWS*COLS | Cells that are reached at the start of a fill |
| maskPlane | input | ROWS*COLS | Cells that the mark may enter |
| dirEn | input | 4 | Enabled directions of travel: bit 0 north, bit 1 south, bit 2 east, bit 3 west |
| reachedPlane | output | ROWS*COLS | Current reached plane |
| done | output | 1 | High once a step adds no new cell |

## Verification
The reached plane equals the seeds one edge after the start edge. After that it grows by one hop per edge. `done` is due exactly k+1 edges after the start edge, where k is the longest shortest-path hop count of the fill. The bench reads the outputs at falling edges. It checks that `done` is still low after k edges, then checks `done` and the full plane after edge k+1. The plane is compared against a separate behavioural fill model in the bench. It then waits further cycles to confirm that the result holds, and repeats this for mid-fill input changes and for restarts.

// File: rtl/flood_pkg.sv
package flood_pkg;

  // Direction-enable bit positions (direction of travel of the mark)
  localparam int DIR_N = 0;
  localparam int DIR_S = 1;
  localparam int DIR_E = 2;
  localparam int DIR_W = 3;
  localparam int DIR_COUNT = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture seeds, mask and directions
    logic step;   // commit one hop of growth
  } floodCtrlT;

  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_RUN  = 1'b1
  } fillStateT;

endpackage

// File: rtl/flood_grow.sv
module flood_grow
  import flood_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int CELLS = ROWS * COLS
) (
  input  logic [CELLS-1:0]     reachedNow,
  input  logic [CELLS-1:0]     maskNow,
  input  logic [DIR_COUNT-1:0] dirNow,
  output logic [CELLS-1:0]     reachedGrown
);

  for (genvar r = 0; r < ROWS; r++) begin : gRow
    for (genvar c = 0; c < COLS; c++) begin : gCol
      localparam int IDX = r * COLS + c;
      logic fromNorth, fromSouth, fromWest, fromEast;
      logic pulled;

      if (r > 0) begin : gHasN
        assign fromNorth = reachedNow[IDX-COLS];
      end else begin : gNoN
        assign fromNorth = 1'b0;
      end

      if (r < ROWS - 1) begin : gHasS
        assign fromSouth = reachedNow[IDX+COLS];
      end else begin : gNoS
        assign fromSouth = 1'b0;
      end

      if (c > 0) begin : gHasW
        assign fromWest = reachedNow[IDX-1];
      end else begin : gNoW
        assign fromWest = 1'b0;
      end

      if (c < COLS - 1) begin : gHasE
        assign fromEast = reachedNow[IDX+1];
      end else begin : gNoE
        assign fromEast = 1'b0;
      end

      // A mark travelling south arrives from the north neighbour, etc.
      assign pulled = (fromSouth & dirNow[DIR_N]) |
                      (fromNorth & dirNow[DIR_S]) |
                      (fromWest  & dirNow[DIR_E]) |
                      (fromEast  & dirNow[DIR_W]);

      assign reachedGrown[IDX] = reachedNow[IDX] | (maskNow[IDX] & pulled);
    end
  end

endmodule

// File: rtl/flood_datapath.sv
module flood_datapath
  import flood_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int CELLS = ROWS * COLS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  floodCtrlT            ctrl,
  input  logic [CELLS-1:0]     seedIn,
  input  logic [CELLS-1:0]     maskIn,
  input  logic [DIR_COUNT-1:0] dirIn,
  output logic [CELLS-1:0]     reachedQ,
  output logic                 settled
);

  logic [CELLS-1:0]     maskQ;
  logic [DIR_COUNT-1:0] dirQ;
  logic [CELLS-1:0]     grown;

  flood_grow #(.ROWS(ROWS), .COLS(COLS)) uGrow (
    .reachedNow  (reachedQ),
    .maskNow     (maskQ),
    .dirNow      (dirQ),
    .reachedGrown(grown)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reachedQ <= '0;
      maskQ    <= '0;
      dirQ     <= '0;
    end else if (ctrl.load) begin
      reachedQ <= seedIn;
      maskQ    <= maskIn;
      dirQ     <= dirIn;
    end else if (ctrl.step) begin
      reachedQ <= grown;
    end
  end

  assign settled = (grown == reachedQ);

endmodule

// File: rtl/flood_ctrl.sv
module flood_ctrl
  import flood_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      settled,
  output floodCtrlT ctrl,
  output logic      fillDone
);

  fillStateT state;

  always_comb begin
    ctrl.load = startPulse;
    ctrl.step = (state == FILL_RUN) && !startPulse && !settled;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= FILL_IDLE;
      fillDone <= 1'b0;
    end else if (startPulse) begin
      state    <= FILL_RUN;
      fillDone <= 1'b0;
    end else if (state == FILL_RUN && settled) begin
      state    <= FILL_IDLE;
      fillDone <= 1'b1;
    end
  end

endmodule

// File: rtl/flood_fill_array.sv
module flood_fill_array
  import flood_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int CELLS = ROWS * COLS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [CELLS-1:0]     seedPlane,
  input  logic [CELLS-1:0]     maskPlane,
  input  logic [DIR_COUNT-1:0] dirEn,
  output logic [CELLS-1:0]     reachedPlane,
  output logic                 done
);

  floodCtrlT ctrlBus;
  logic      settled;

  flood_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(start),
    .settled   (settled),
    .ctrl      (ctrlBus),
    .fillDone  (done)
  );

  flood_datapath #(.ROWS(ROWS), .COLS(COLS)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrlBus),
    .seedIn  (seedPlane),
    .maskIn  (maskPlane),
    .dirIn   (dirEn),
    .reachedQ(reachedPlane),
    .settled (settled)
  );

endmodule

// File: rtl/flood_fill_checker.sv
module flood_fill_checker #(
  parameter int CELLS = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [CELLS-1:0] seedPlane,
  input logic [CELLS-1:0] reachedPlane,
  input logic             done
);

  // R2: the start edge clears done
  assert_start_clears_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !done);

  // R2: after the start edge the plane equals the seeds exactly
  assert_start_loads_seeds_R2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (reachedPlane == $past(seedPlane)));

  // R7: no reached bit is cleared while no start arrives
  assert_no_bit_lost_R7: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ((reachedPlane & $past(reachedPlane)) == $past(reachedPlane)));

  // R7: a finished result holds until the next start
  assert_result_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(reachedPlane)));

  // R6: done rises only on an edge where the plane did not grow
  assert_done_when_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $stable(reachedPlane));

endmodule

bind flood_fill_array flood_fill_checker #(.CELLS(CELLS)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .seedPlane   (seedPlane),
  .reachedPlane(reachedPlane),
  .done        (done)
);

// File: tb/sim_flood_fill_array.sv
`timescale 1ns/1ps
module sim_flood_fill_array;

  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int CELLS = ROWS * COLS;

  typedef struct packed {
    logic [CELLS-1:0] seed;
    logic [CELLS-1:0] mask;
    logic [3:0]       dir;
    logic [7:0]       hops;
  } vecT;

  localparam int NVEC = 10;
  localparam vecT VECS [NVEC] = '{
    '{64'h1,                  {64{1'b1}},             4'b1111, 8'd14}, // R3 all dirs
    '{64'h1,                  {64{1'b1}},             4'b0100, 8'd7},  // R4 east only
    '{64'h1,                  {64{1'b1}},             4'b0010, 8'd7},  // R4 south only
    '{64'h8000000000000000,   {64{1'b1}},             4'b1001, 8'd14}, // R3 north+west
    '{64'h1,                  64'h0,                  4'b1111, 8'd0},  // R2 seed despite mask
    '{64'h1,                  64'hF7F7F7F7F7F7F7F7,   4'b1111, 8'd9},  // R4 wall column
    '{64'h1,                  64'hFFFFFFFFFFFFFFEF,   4'b0100, 8'd3},  // R4 blocked cell
    '{64'h8000000000000001,   {64{1'b1}},             4'b0000, 8'd0},  // R4 no directions
    '{64'h80,                 {64{1'b1}},             4'b0100, 8'd0},  // R5 no east wrap
    '{64'h100,                {64{1'b1}},             4'b1000, 8'd0}   // R5 no west wrap
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [CELLS-1:0] seedPlane = '0;
  logic [CELLS-1:0] maskPlane = '0;
  logic [3:0]       dirEn = '0;
  logic [CELLS-1:0] reachedPlane;
  logic             done;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  flood_fill_array #(.ROWS(ROWS), .COLS(COLS)) u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .seedPlane(seedPlane), .maskPlane(maskPlane), .dirEn(dirEn),
    .reachedPlane(reachedPlane), .done(done)
  );

  // Independent behavioural fill: repeat neighbour scans until nothing changes
  function automatic logic [CELLS-1:0] refFill(input logic [CELLS-1:0] s,
                                              input logic [CELLS-1:0] m,
                                              input logic [3:0] d);
    logic [CELLS-1:0] cur, nxt;
    cur = s;
    for (int it = 0; it < CELLS + 1; it++) begin
      nxt = cur;
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          if (m[r*COLS+c]) begin
            if (d[0] && r + 1 < ROWS && cur[(r+1)*COLS+c]) nxt[r*COLS+c] = 1'b1;
            if (d[1] && r > 0        && cur[(r-1)*COLS+c]) nxt[r*COLS+c] = 1'b1;
            if (d[2] && c > 0        && cur[r*COLS+c-1])   nxt[r*COLS+c] = 1'b1;
            if (d[3] && c + 1 < COLS && cur[r*COLS+c+1])   nxt[r*COLS+c] = 1'b1;
          end
        end
      end
      cur = nxt;
    end
    return cur;
  endfunction

  task automatic checkBit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic checkPlane(input string req, input string what,
                            input logic [CELLS-1:0] act, input logic [CELLS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Pulse start on one edge; returns at the falling edge just after it
  task automatic pulseStart(input logic [CELLS-1:0] s, input logic [CELLS-1:0] m,
                            input logic [3:0] d);
    @(negedge clk);
    seedPlane = s; maskPlane = m; dirEn = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // R6 timing plus final plane, called at the falling edge after the start edge
  task automatic awaitResult(input string req, input int hops, input logic [CELLS-1:0] exp);
    repeat (hops) @(negedge clk);
    checkBit("R6", "done low one edge early", done, 1'b0);
    @(negedge clk);
    checkBit("R6", "done due at k+1", done, 1'b1);
    checkPlane(req, "final plane", reachedPlane, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [CELLS-1:0] expPlane;
    // R1: reset state
    repeat (3) @(negedge clk);
    checkPlane("R1", "plane in reset", reachedPlane, '0);
    checkBit("R1", "done in reset", done, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkPlane("R1", "plane after reset", reachedPlane, '0);
    checkBit("R1", "done after reset", done, 1'b0);

    // Table walk: R2..R6
    for (int v = 0; v < NVEC; v++) begin
      expPlane = refFill(VECS[v].seed, VECS[v].mask, VECS[v].dir);
      pulseStart(VECS[v].seed, VECS[v].mask, VECS[v].dir);
      if (VECS[v].hops != 0)
        checkPlane("R2", "seeds loaded", reachedPlane, VECS[v].seed);
      awaitResult(v >= 8 ? "R5" : (v == 4 ? "R2" : "R4"), int'(VECS[v].hops), expPlane);
    end

    // R3: one hop per clock, east-only row fill grows one cell per edge
    pulseStart(64'h1, {64{1'b1}}, 4'b0100);
    checkPlane("R3", "after start", reachedPlane, 64'h01);
    @(negedge clk);
    checkPlane("R3", "after hop 1", reachedPlane, 64'h03);
    @(negedge clk);
    checkPlane("R3", "after hop 2", reachedPlane, 64'h07);
    repeat (6) @(negedge clk);
    checkBit("R6", "east row done", done, 1'b1);

    // R7: result holds after done
    expPlane = reachedPlane;
    repeat (5) @(negedge clk);
    checkBit("R7", "done holds", done, 1'b1);
    checkPlane("R7", "plane holds", reachedPlane, expPlane);

    // R8: mask and directions changed mid-fill are ignored
    pulseStart(64'h1, {64{1'b1}}, 4'b1111);
    maskPlane = '0; dirEn = 4'b0000;
    awaitResult("R8", 14, {64{1'b1}});

    // R9: restart during a fill
    pulseStart(64'h1, {64{1'b1}}, 4'b1111);
    repeat (3) @(negedge clk);
    pulseStart(64'h1, {64{1'b1}}, 4'b0010);
    checkPlane("R9", "restart reloads seeds", reachedPlane, 64'h1);
    awaitResult("R9", 7, 64'h0101010101010101);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule